// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block measures activity inside a processor core. It holds one free-running cycle counter and two event counters, each 32 bits wide. Each event counter follows one of up to 256 single-cycle event inputs, chosen by an 8-bit selector. When a counter wraps past its all-ones value, a sticky flag is set. Each flag can be routed through its own enable bit to a level interrupt line.

Software reaches the block through a small register port with four word addresses. Index 0 holds one packed control word, index 1 the cycle counter, and indexes 2 and 3 the two event counters. The control word carries the global run bit, two reset strobes, a divide-by-64 option for the cycle counter, the interrupt enables, the overflow flags (cleared by writing ones) and both selectors. Reads are combinational. Writes take effect at the clock edge where the write strobe is sampled.

Top module: `perf_counter_unit`

## Requirements
- R1: Writing index 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1 with the written value. The new value is readable at that index right after the write edge. A load has priority over a reset strobe and over counting.
- R2: While control bit 0 (run) is 0, no counter changes except by a load or a reset strobe, even when event pulses arrive.
- R3: Writing control bit 1 as 1 clears both event counters. Writing control bit 2 as 1 clears the cycle counter and the divide-by-64 phase. Neither strobe is stored: both always read back as 0.
- R4: While running with control bit 3 at 0, the cycle counter advances by one on every clock. With bit 3 at 1, it advances once every 64 clocks. The first step comes 64 clocks after a cycle reset strobe.
- R5: While running, event counter 0 (selector in control bits 12-19) and event counter 1 (selector in bits 20-27) advance by one at the edge where event input number `selector` is high.
- R6: A selector value of 0xFF means no event. That counter never advances, even when event input 255 is high.
- R7: A counter step from 0xFFFFFFFF to 0 sets a sticky overflow flag at the same edge. The flag is bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R8: Writing the control word with a 1 in a flag bit clears that flag. A 0 leaves it unchanged. If a set and a clear hit the same flag at one edge, the set wins. An overflow never clears another counter's flag.
- R9: `irqOut` is high exactly when some flag is set and its interrupt enable is set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R10: Control bits 7, 11 and 28-31 are not stored and always read as 0.
- R11: After reset, all counters are 0, run, divide, enables and flags are 0, both selectors hold 0xFF (control word reads 0x0FFFF000), and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe for one cycle |
| regAddr | input | 2 | Register index: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| eventPulses | input | 256 | One-cycle event pulses, indexed by event code |
| irqOut | output | 1 | Level interrupt: a flag and its enable are both set |

## Verification
Every result of this block is due at the first rising edge after its cause. Loads, strobes, event steps and selector changes show at the read port just after the edge that samples them. An overflow flag and the interrupt level change at the same edge as the wrap. The one exception is the divided cycle count, whose first step lands exactly 64 edges after a cycle reset strobe. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then reads the combinational port a time unit later, so each check samples exactly one edge after its cause. For the cycle counter it counts the rising edges it waits, both plain and divided, so the expected value follows from the elapsed edges.

// File: rtl/perf_counter_pkg.sv
package perf_counter_pkg;

  localparam int CNT_W         = 32;
  localparam int SEL_W         = 8;
  localparam int NUM_EVT_CNT   = 2;
  localparam int NUM_SLOTS     = NUM_EVT_CNT + 1;   // event counters first, cycle counter last
  localparam int NUM_CODES     = 1 << SEL_W;
  localparam int CTRL_W        = 32;
  localparam int ADDR_W        = $clog2(NUM_SLOTS + 1);

  localparam logic [SEL_W-1:0] NO_EVENT = '1;

  // control word layout
  localparam int RUN_BIT     = 0;
  localparam int CLR_EVT_BIT = 1;
  localparam int CLR_CYC_BIT = 2;
  localparam int DIV_BIT     = 3;
  localparam int IE_LSB      = 4;
  localparam int FLAG_LSB    = 8;
  localparam int SEL_LSB     = 12;
  localparam int SEL_MSB     = SEL_LSB + NUM_EVT_CNT * SEL_W - 1;

  localparam logic [ADDR_W-1:0] CTRL_ADDR     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CYC_ADDR      = ADDR_W'(1);
  localparam int                EVT_BASE_ADDR = 2;

  typedef struct packed {
    logic                 clrEvt;
    logic                 clrCyc;
    logic [NUM_SLOTS-1:0] wrCnt;
  } dpStrobes_t;

  typedef struct packed {
    logic                                run;
    logic                                divide;
    logic [NUM_EVT_CNT-1:0][SEL_W-1:0]   sel;
  } dpConfig_t;

  function automatic logic [ADDR_W-1:0] slotAddr(input int slot);
    if (slot == NUM_EVT_CNT) return CYC_ADDR;
    return ADDR_W'(EVT_BASE_ADDR + slot);
  endfunction

endpackage

// File: rtl/perf_counter_slot.sv
module perf_counter_slot #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             clearEn,
  input  logic             incEn,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        countQ <= '0;
    else if (loadEn)  countQ <= loadVal;
    else if (clearEn) countQ <= '0;
    else if (incEn)   countQ <= countQ + CNT_W'(1);
  end

  assign count = countQ;
  assign wrap  = incEn && !loadEn && !clearEn && (&countQ);

  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> countQ == $past(loadVal));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clearEn && !loadEn) |=> countQ == '0);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !loadEn && !clearEn) |=> countQ == $past(countQ) + CNT_W'(1));

endmodule

// File: rtl/perf_datapath.sv
module perf_datapath
  import perf_counter_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpStrobes_t                       strobes,
  input  dpConfig_t                        cfg,
  input  logic [CNT_W-1:0]                 wrData,
  input  logic [NUM_CODES-1:0]             eventPulses,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]  counts,
  output logic [NUM_SLOTS-1:0]             wrapPulse
);

  localparam int CYC_SLOT = NUM_EVT_CNT;

  logic [DIV_LOG2-1:0] divPhase;
  logic                divTick;
  logic                cycInc;

  // divide-by-2^DIV_LOG2 phase, restarted by the cycle reset strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divPhase <= '0;
    else if (strobes.clrCyc)  divPhase <= '0;
    else if (cfg.run)         divPhase <= divPhase + DIV_LOG2'(1);
  end

  assign divTick = &divPhase;
  assign cycInc  = cfg.run && (!cfg.divide || divTick);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic incS;
    logic clrS;
    if (s < NUM_EVT_CNT) begin : g_evt
      assign incS = cfg.run && (cfg.sel[s] != NO_EVENT) && eventPulses[cfg.sel[s]];
      assign clrS = strobes.clrEvt;
    end else begin : g_cyc
      assign incS = cycInc;
      assign clrS = strobes.clrCyc;
    end

    perf_counter_slot #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .loadEn  (strobes.wrCnt[s]),
      .loadVal (wrData),
      .clearEn (clrS),
      .incEn   (incS),
      .count   (counts[s]),
      .wrap    (wrapPulse[s])
    );

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!cfg.run && !strobes.wrCnt[s] && !strobes.clrEvt && !strobes.clrCyc)
      |=> $stable(counts[s]));
  end

  assert_divide_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.divide && !divTick && !strobes.clrCyc && !strobes.wrCnt[CYC_SLOT])
    |=> $stable(counts[CYC_SLOT]));

  assert_no_event_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.sel[0] == NO_EVENT && !strobes.wrCnt[0] && !strobes.clrEvt)
    |=> $stable(counts[0]));

endmodule

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import perf_counter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [CTRL_W-1:0]    regWrData,
  input  logic [NUM_SLOTS-1:0] wrapPulse,
  output dpStrobes_t           strobes,
  output dpConfig_t            cfg,
  output logic [CTRL_W-1:0]    ctrlWord,
  output logic                 irqOut
);

  logic                              ctrlWr;
  logic                              runQ;
  logic                              divideQ;
  logic [NUM_SLOTS-1:0]              ieQ;
  logic [NUM_SLOTS-1:0]              flagQ;
  logic [NUM_SLOTS-1:0]              flagClr;
  logic [NUM_SLOTS-1:0]              flagNext;
  logic [NUM_EVT_CNT-1:0][SEL_W-1:0] selQ;
  logic                              unusedRsvd;

  assign ctrlWr = regWrEn && (regAddr == CTRL_ADDR);

  assign flagClr  = ctrlWr ? regWrData[FLAG_LSB +: NUM_SLOTS] : '0;
  assign flagNext = (flagQ & ~flagClr) | wrapPulse;   // a new wrap beats a clear

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      divideQ <= 1'b0;
      ieQ     <= '0;
      flagQ   <= '0;
      for (int i = 0; i < NUM_EVT_CNT; i++) selQ[i] <= NO_EVENT;
    end else begin
      flagQ <= flagNext;
      if (ctrlWr) begin
        runQ    <= regWrData[RUN_BIT];
        divideQ <= regWrData[DIV_BIT];
        ieQ     <= regWrData[IE_LSB +: NUM_SLOTS];
        for (int i = 0; i < NUM_EVT_CNT; i++)
          selQ[i] <= regWrData[SEL_LSB + i*SEL_W +: SEL_W];
      end
    end
  end

  always_comb begin
    strobes.clrEvt = ctrlWr && regWrData[CLR_EVT_BIT];
    strobes.clrCyc = ctrlWr && regWrData[CLR_CYC_BIT];
    for (int s = 0; s < NUM_SLOTS; s++)
      strobes.wrCnt[s] = regWrEn && (regAddr == slotAddr(s));
  end

  always_comb begin
    cfg.run    = runQ;
    cfg.divide = divideQ;
    cfg.sel    = selQ;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[RUN_BIT]                = runQ;
    ctrlWord[DIV_BIT]                = divideQ;
    ctrlWord[IE_LSB +: NUM_SLOTS]    = ieQ;
    ctrlWord[FLAG_LSB +: NUM_SLOTS]  = flagQ;
    for (int i = 0; i < NUM_EVT_CNT; i++)
      ctrlWord[SEL_LSB + i*SEL_W +: SEL_W] = selQ[i];
  end

  assign irqOut = |(flagQ & ieQ);

  // reserved write bits are dropped
  assign unusedRsvd = &{1'b0, regWrData[7], regWrData[11], regWrData[CTRL_W-1:SEL_MSB+1]};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flagChk
    assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
      wrapPulse[s] |=> flagQ[s]);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[s] && !(ctrlWr && regWrData[FLAG_LSB + s])) |=> flagQ[s]);

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlWr && regWrData[FLAG_LSB + s] && !wrapPulse[s]) |=> !flagQ[s]);
  end

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[IE_LSB +: NUM_SLOTS] == '0) |=> !irqOut);

  assert_strobe_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrEvt || strobes.clrCyc) |-> (regWrEn && regAddr == CTRL_ADDR));

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perf_counter_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [CTRL_W-1:0]     regWrData,
  output logic [CTRL_W-1:0]     regRdData,
  input  logic [NUM_CODES-1:0]  eventPulses,
  output logic                  irqOut
);

  dpStrobes_t                      strobes;
  dpConfig_t                       cfg;
  logic [CTRL_W-1:0]               ctrlWord;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] counts;
  logic [NUM_SLOTS-1:0]            wrapPulse;

  perf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .wrapPulse (wrapPulse),
    .strobes   (strobes),
    .cfg       (cfg),
    .ctrlWord  (ctrlWord),
    .irqOut    (irqOut)
  );

  perf_datapath #(.DIV_LOG2(DIV_LOG2)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfg         (cfg),
    .wrData      (regWrData),
    .eventPulses (eventPulses),
    .counts      (counts),
    .wrapPulse   (wrapPulse)
  );

  always_comb begin
    regRdData = ctrlWord;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (regAddr == slotAddr(s)) regRdData = counts[s];
  end

endmodule

// File: tb/tb_perf_counter_unit.sv
module tb_perf_counter_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [255:0] eventPulses = '0;
  logic         irqOut;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  perf_counter_unit dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .eventPulses(eventPulses), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [1:0]  wAddr;
    logic [31:0] wData;
    logic        pEn;
    logic [7:0]  code;
    logic [1:0]  cAddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd2, 32'h12345678, 1'b0, 8'h00, 2'd2, 32'h12345678, 4'd1},  // R1 load event 0
    '{1'b1, 2'd3, 32'hCAFEF00D, 1'b0, 8'h00, 2'd3, 32'hCAFEF00D, 4'd1},  // R1 load event 1
    '{1'b1, 2'd1, 32'hDEADBEEF, 1'b0, 8'h00, 2'd1, 32'hDEADBEEF, 4'd1},  // R1 load cycle
    '{1'b1, 2'd0, 32'hF0FFF8F0, 1'b0, 8'h00, 2'd0, 32'h00FFF070, 4'd10}, // R10 reserved dropped
    '{1'b0, 2'd0, 32'h0,        1'b1, 8'h0F, 2'd3, 32'hCAFEF00D, 4'd2},  // R2 halted
    '{1'b1, 2'd0, 32'h00FFF001, 1'b0, 8'h00, 2'd0, 32'h00FFF001, 4'd10}, // run on
    '{1'b0, 2'd0, 32'h0,        1'b1, 8'h0F, 2'd3, 32'hCAFEF00E, 4'd5},  // R5 selected event
    '{1'b0, 2'd0, 32'h0,        1'b1, 8'hFF, 2'd2, 32'h12345678, 4'd6},  // R6 no-event code
    '{1'b0, 2'd0, 32'h0,        1'b1, 8'h0E, 2'd3, 32'hCAFEF00E, 4'd5},  // R5 other code ignored
    '{1'b1, 2'd0, 32'h00FFF003, 1'b0, 8'h00, 2'd2, 32'h00000000, 4'd3},  // R3 event clear
    '{1'b0, 2'd0, 32'h0,        1'b0, 8'h00, 2'd3, 32'h00000000, 4'd3},  // R3 both cleared
    '{1'b0, 2'd0, 32'h0,        1'b0, 8'h00, 2'd0, 32'h00FFF001, 4'd3},  // R3 strobe reads 0
    '{1'b1, 2'd0, 32'h00FFF000, 1'b0, 8'h00, 2'd0, 32'h00FFF000, 4'd2}   // run off
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] a, input logic [31:0] d,
                       input logic p, input logic [7:0] c);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d;
    eventPulses = '0;
    if (p) eventPulses[c] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    eventPulses = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 8'h00);
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    readReg(2'd0, v); check("R11 ctrl", v, 32'h0FFFF000);
    readReg(2'd1, v); check("R11 cycle", v, 32'h0);
    readReg(2'd2, v); check("R11 event0", v, 32'h0);
    readReg(2'd3, v); check("R11 event1", v, 32'h0);
    check("R11 irq", {31'b0, irqOut}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].wr, VECS[i].wAddr, VECS[i].wData, VECS[i].pEn, VECS[i].code);
      readReg(VECS[i].cAddr, v);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R4 plain cycle counting
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h00FFF001);
    waitEdges(10);
    readReg(2'd1, v); check("R4 every clock", v, 32'd110);

    // R4 divided counting: clear strobe restarts the phase
    wr(2'd0, 32'h00FFF00D);
    waitEdges(63);
    readReg(2'd1, v); check("R4 divide before 64", v, 32'd0);
    waitEdges(1);
    readReg(2'd1, v); check("R4 divide at 64", v, 32'd1);

    // R7 R8 R9 overflow flags
    wr(2'd0, 32'h00FFF000);
    wr(2'd2, 32'hFFFFFFFF);
    wr(2'd3, 32'hFFFFFFFF);
    wr(2'd0, 32'h00605011);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 8'h05);
    readReg(2'd0, v); check("R7 event0 flag", v, 32'h00605111);
    readReg(2'd2, v); check("R7 event0 wrapped", v, 32'h0);
    check("R9 irq on", {31'b0, irqOut}, 32'h1);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 8'h06);
    readReg(2'd0, v); check("R8 other flag kept", v, 32'h00605311);
    wr(2'd0, 32'h00605111);
    readReg(2'd0, v); check("R8 clear one flag", v, 32'h00605211);
    check("R9 irq masked", {31'b0, irqOut}, 32'h0);
    wr(2'd2, 32'hFFFFFFFF);
    drive(1'b1, 2'd0, 32'h00605111, 1'b1, 8'h05);
    readReg(2'd0, v); check("R8 set wins", v, 32'h00605311);
    check("R9 irq set wins", {31'b0, irqOut}, 32'h1);
    wr(2'd0, 32'h00605741);
    readReg(2'd0, v); check("R8 clear all", v, 32'h00605041);
    check("R9 irq off", {31'b0, irqOut}, 32'h0);
    wr(2'd1, 32'hFFFFFFFE);
    waitEdges(2);
    readReg(2'd0, v); check("R7 cycle flag", v, 32'h00605441);
    readReg(2'd1, v); check("R7 cycle wrapped", v, 32'h0);
    check("R9 irq cycle", {31'b0, irqOut}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule